// File: doc/BRIEF.md
# Cascaded Auxiliary Timer with Toggle-Clocked Counter

This block holds two timers that can be chained. The core timer counts up or down on every system clock while it runs. When it passes its end value (all ones going up, zero going down) it loads a software-held reload value. On that same edge it inverts a single-bit toggle latch, which also drives an output pin.

The auxiliary timer works in one of two modes. In timer mode it counts ticks of a free-running prescaler that divides the system clock by a power of two. In counter mode it counts transitions of the core timer's toggle latch: rising only, falling only, or both, as a 3-bit source code selects. Each time it wraps it raises a request flag. If enabled, a rising edge on an external event input copies the current auxiliary count into a capture register and raises a second flag.

Software sees the block through a small register port. It holds the two control words, both counters, the reload value, the capture register and a flag word. A register write to a counter takes effect in place of any count in that cycle.

Top module: `cascade_timer`

## Requirements
- R1: After reset every register reads zero, and toggle_out, aux_req and cap_req are low.
- R2: With core control bit0 (run) = 1 and bit1 (down) = 0, the core count (address 1) rises by one per clock. A clock at which it holds all ones loads the reload value (address 2) instead and inverts toggle_out.
- R3: With core control bits {down,run} = 11b, the core count falls by one per clock. A clock at which it holds zero loads the reload value and inverts toggle_out.
- R4: The auxiliary control word (address 3) holds mode in bits [1:0], source in [4:2], run in bit5, down in bit6, prescale in [9:7] and capture enable in bit10. With mode 01b and source 101b, the auxiliary count (address 4) steps once for each 0-to-1 change of the toggle latch, one clock after the latch changes.
- R5: With mode 01b and source 110b, the auxiliary count steps once for each 1-to-0 change of the toggle latch.
- R6: With mode 01b and source 111b, the auxiliary count steps once for every change of the toggle latch.
- R7: Mode 01b with source codes 000b to 100b, and modes 10b and 11b, never step the auxiliary count.
- R8: Mode 00b steps the auxiliary count once every 2^prescale system clocks while run is set.
- R9: A step from all ones up, or from zero down, wraps the auxiliary count and sets the wrap flag (flag word bit0 at address 6, and aux_req). The flag stays set until software writes the flag word. The flag word's bit1 is the capture flag and bit2 reads the toggle latch.
- R10: With capture enable set, a rising edge on cap_evt copies the auxiliary count from before that clock's step into the capture register (address 5) and sets cap_req. With capture enable clear, the edge changes neither. The capture register ignores writes.
- R11: A write to a counter address loads the written value in that clock, and any count step in the same clock is dropped.
- R12: With auxiliary down (bit6) set, each step decrements the auxiliary count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W | Read data for rd_addr (combinational) |
| cap_evt | input | 1 | External capture event, rising edge acts |
| toggle_out | output | 1 | Core timer toggle latch |
| aux_req | output | 1 | Auxiliary wrap request flag |
| cap_req | output | 1 | Capture request flag |

## Verification
Two functions can fall in the same clock. A software write to the auxiliary count can arrive in a clock where the timer would also step. A capture event can arrive in a clock where the count steps. The bench writes the count while the timer runs at prescale zero, so a step is due in every clock. It expects exactly the written value after that edge and that value plus one a clock later. It raises cap_evt in a clock where a step is due, and expects the capture register to hold the count from before the step while the live count has already moved on by one.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

    localparam int PRE_W = 3;

    typedef enum logic [2:0] {
        REG_CORE_CTL = 3'd0,
        REG_CORE_CNT = 3'd1,
        REG_CORE_RLD = 3'd2,
        REG_AUX_CTL  = 3'd3,
        REG_AUX_CNT  = 3'd4,
        REG_CAPT     = 3'd5,
        REG_FLAGS    = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_COUNTER = 2'b01,
        MODE_RSV2    = 2'b10,
        MODE_RSV3    = 2'b11
    } aux_mode_e;

    localparam logic [2:0] SRC_RISE = 3'b101;
    localparam logic [2:0] SRC_FALL = 3'b110;
    localparam logic [2:0] SRC_ANY  = 3'b111;

    typedef struct packed {
        logic             down;
        logic             run;
    } core_ctl_t;

    typedef struct packed {
        logic             cap_en;
        logic [PRE_W-1:0] pre;
        logic             down;
        logic             run;
        logic [2:0]       src;
        aux_mode_e        mode;
    } aux_ctl_t;

endpackage

// File: rtl/ct_prescale.sv
module ct_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PSW-1:0] sel,
    output logic           tick
);
    localparam int DIV_W = (1 << PSW) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = ~({DIV_W{1'b1}} << sel);
        tick  = ((div_q & mask) == mask);
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/ct_core.sv
module ct_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         down,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         tgl
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tgl;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = run && !wr_cnt &&
               (down ? (st_q.cnt == '0) : (st_q.cnt == '1));
        if (wr_cnt) begin
            st_d.cnt = wr_data;
        end else if (wrap) begin
            st_d.cnt = reload;
            st_d.tgl = ~st_q.tgl;
        end else if (run) begin
            st_d.cnt = down ? (st_q.cnt - 1'b1) : (st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign tgl = st_q.tgl;
endmodule

// File: rtl/ct_aux.sv
module ct_aux
    import cascade_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  aux_ctl_t     cfg,
    input  logic         tick,
    input  logic         tgl,
    input  logic         wr_cnt,
    input  logic         wr_flags,
    input  logic [W-1:0] wr_data,
    input  logic         cap_evt,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         wrap,
    output logic         wrap_flag,
    output logic         cap_flag
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
        logic         tgl_prev;
        logic         evt_prev;
        logic         wrap_flag;
        logic         cap_flag;
    } aux_st_t;

    aux_st_t st_d, st_q;
    logic    rise, fall, sel_step, step, cap_hit;

    // source select: prescaler tick or chosen toggle-latch edge
    always_comb begin
        rise     = tgl & ~st_q.tgl_prev;
        fall     = ~tgl & st_q.tgl_prev;
        sel_step = 1'b0;
        case (cfg.mode)
            MODE_TIMER: sel_step = tick;
            MODE_COUNTER: begin
                case (cfg.src)
                    SRC_RISE: sel_step = rise;
                    SRC_FALL: sel_step = fall;
                    SRC_ANY:  sel_step = rise | fall;
                    default:  sel_step = 1'b0;
                endcase
            end
            default: sel_step = 1'b0;
        endcase
    end

    always_comb begin
        step    = sel_step & cfg.run & ~wr_cnt;
        wrap    = step && (cfg.down ? (st_q.cnt == '0) : (st_q.cnt == '1));
        cap_hit = cfg.cap_en & cap_evt & ~st_q.evt_prev;

        st_d          = st_q;
        st_d.tgl_prev = tgl;
        st_d.evt_prev = cap_evt;

        if (wr_cnt) begin
            st_d.cnt = wr_data;
        end else if (step) begin
            st_d.cnt = cfg.down ? (st_q.cnt - 1'b1) : (st_q.cnt + 1'b1);
        end

        if (cap_hit) st_d.cap = st_q.cnt;

        if (wr_flags) begin
            st_d.wrap_flag = wr_data[0];
            st_d.cap_flag  = wr_data[1];
        end
        st_d.wrap_flag = st_d.wrap_flag | wrap;
        st_d.cap_flag  = st_d.cap_flag | cap_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign cap       = st_q.cap;
    assign wrap_flag = st_q.wrap_flag;
    assign cap_flag  = st_q.cap_flag;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import cascade_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         cap_evt,
    output logic         toggle_out,
    output logic         aux_req,
    output logic         cap_req
);
    localparam int AUX_CTL_W  = $bits(aux_ctl_t);
    localparam int CORE_CTL_W = $bits(core_ctl_t);

    typedef struct packed {
        core_ctl_t    core;
        logic [W-1:0] rld;
        aux_ctl_t     aux;
    } regs_t;

    regs_t        regs_d, regs_q;
    logic         wr_core_ctl, wr_core_cnt, wr_rld;
    logic         wr_aux_ctl, wr_aux_cnt, wr_flags;
    logic         pre_tick;
    logic [W-1:0] core_cnt, aux_cnt, cap_val;
    logic         core_wrap, aux_wrap, tgl;

    always_comb begin
        wr_core_ctl = wr_en && (reg_sel_e'(wr_addr) == REG_CORE_CTL);
        wr_core_cnt = wr_en && (reg_sel_e'(wr_addr) == REG_CORE_CNT);
        wr_rld      = wr_en && (reg_sel_e'(wr_addr) == REG_CORE_RLD);
        wr_aux_ctl  = wr_en && (reg_sel_e'(wr_addr) == REG_AUX_CTL);
        wr_aux_cnt  = wr_en && (reg_sel_e'(wr_addr) == REG_AUX_CNT);
        wr_flags    = wr_en && (reg_sel_e'(wr_addr) == REG_FLAGS);

        regs_d = regs_q;
        if (wr_core_ctl) regs_d.core = core_ctl_t'(wr_data[CORE_CTL_W-1:0]);
        if (wr_rld)      regs_d.rld  = wr_data;
        if (wr_aux_ctl)  regs_d.aux  = aux_ctl_t'(wr_data[AUX_CTL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    ct_prescale #(.PSW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (regs_q.aux.pre),
        .tick  (pre_tick)
    );

    ct_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (regs_q.core.run),
        .down    (regs_q.core.down),
        .wr_cnt  (wr_core_cnt),
        .wr_data (wr_data),
        .reload  (regs_q.rld),
        .cnt     (core_cnt),
        .wrap    (core_wrap),
        .tgl     (tgl)
    );

    ct_aux #(.W(W)) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (regs_q.aux),
        .tick      (pre_tick),
        .tgl       (tgl),
        .wr_cnt    (wr_aux_cnt),
        .wr_flags  (wr_flags),
        .wr_data   (wr_data),
        .cap_evt   (cap_evt),
        .cnt       (aux_cnt),
        .cap       (cap_val),
        .wrap      (aux_wrap),
        .wrap_flag (aux_req),
        .cap_flag  (cap_req)
    );

    assign toggle_out = tgl;

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            REG_CORE_CTL: rd_data = W'(regs_q.core);
            REG_CORE_CNT: rd_data = core_cnt;
            REG_CORE_RLD: rd_data = regs_q.rld;
            REG_AUX_CTL:  rd_data = W'(regs_q.aux);
            REG_AUX_CNT:  rd_data = aux_cnt;
            REG_CAPT:     rd_data = cap_val;
            REG_FLAGS:    rd_data = W'({tgl, cap_req, aux_req});
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         core_wrap,
    input logic         tgl,
    input logic [W-1:0] core_cnt,
    input logic [W-1:0] aux_cnt,
    input logic         aux_wrap,
    input logic         aux_req,
    input logic [W-1:0] cap_val,
    input logic         cap_en,
    input logic [1:0]   mode,
    input logic [2:0]   src
);
    logic aux_written;
    assign aux_written = wr_en && (wr_addr == 3'd4);

    // R11: aux counter write overrides a step
    p_wr_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        aux_written |=> (aux_cnt == $past(wr_data)));

    // R11: core counter write overrides a step
    p_core_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> (core_cnt == $past(wr_data)));

    // R2: a core wrap inverts the latch
    p_tgl_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_wrap |=> (tgl != $past(tgl)));

    // R3: without a core wrap the latch holds
    p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_wrap |=> (tgl == $past(tgl)));

    // R8: at most one step per clock
    p_unit_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_written |=> ((aux_cnt == $past(aux_cnt)) ||
                          (aux_cnt == $past(aux_cnt) + W'(1)) ||
                          (aux_cnt == $past(aux_cnt) - W'(1))));

    // R7: reserved sources and modes never step
    p_rsv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode == 2'b01) && (src < 3'd5)) || mode[1]) && !aux_written
        |=> $stable(aux_cnt));

    // R10: capture disabled keeps the capture register
    p_cap_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_val));

    // R9: wrap raises the request
    p_req_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aux_wrap |=> aux_req);
endmodule

bind cascade_timer cascade_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .core_wrap (core_wrap),
    .tgl       (tgl),
    .core_cnt  (core_cnt),
    .aux_cnt   (aux_cnt),
    .aux_wrap  (aux_wrap),
    .aux_req   (aux_req),
    .cap_val   (cap_val),
    .cap_en    (regs_q.aux.cap_en),
    .mode      (regs_q.aux.mode),
    .src       (regs_q.aux.src)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_evt = 1'b0;
    logic        toggle_out, aux_req, cap_req;

    cascade_timer #(.W(16)) u_cascade_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_evt(cap_evt), .toggle_out(toggle_out), .aux_req(aux_req),
        .cap_req(cap_req)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int  pend = 0, served = 0;
    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    // monitor: pops expected items and compares against the design
    initial begin
        sb_item_t    it;
        logic [15:0] act;
        forever begin
            wait (pend != served);
            #0.2;
            it = sb_q.pop_front();
            case (it.src)
                7:       act = {15'b0, toggle_out};
                8:       act = {15'b0, aux_req};
                9:       act = {15'b0, cap_req};
                default: act = rd_data;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
            served++;
        end
    end

    task automatic expect_val(input int src, input logic [15:0] exp, input string tag);
        sb_item_t it;
        if (src < 7) rd_addr = 3'(src);
        it.src = src;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        pend++;
        wait (served == pend);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] aux_word(input int mode, input int src, input bit run,
                                             input bit down, input int pre, input bit cap_en);
        return 16'(mode & 3) | (16'(src & 7) << 2) | (16'(run) << 5) |
               (16'(down) << 6) | (16'(pre & 7) << 7) | (16'(cap_en) << 10);
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bit          t;
        logic [15:0] exp;
        int          modes[5] = '{1, 1, 1, 1, 2};
        int          srcs[5]  = '{5, 6, 7, 4, 7};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) expect_val(a, 16'h0000, "R1 register reset");
        expect_val(7, 16'h0, "R1 toggle_out reset");
        expect_val(8, 16'h0, "R1 aux_req reset");
        expect_val(9, 16'h0, "R1 cap_req reset");
        @(negedge clk);
        t = 1'b0;

        // R2 core up count with reload and toggle
        reg_wr(3'd2, 16'hFFFC);
        reg_wr(3'd1, 16'hFFFD);
        reg_wr(3'd0, 16'h0001);
        expect_val(1, 16'hFFFD, "R2 core start value");
        step(2);
        expect_val(1, 16'hFFFF, "R2 core counts up");
        expect_val(7, 16'h0, "R2 toggle before overflow");
        step(1);
        expect_val(1, 16'hFFFC, "R2 overflow reloads");
        expect_val(7, 16'h1, "R2 toggle after overflow");
        step(4);
        expect_val(7, 16'h0, "R2 toggle after second overflow");
        reg_wr(3'd0, 16'h0000);
        step(3);
        expect_val(1, 16'hFFFD, "R2 core halted");

        // R3 core down count with underflow
        reg_wr(3'd1, 16'h0002);
        reg_wr(3'd2, 16'h0005);
        reg_wr(3'd0, 16'h0003);
        step(2);
        expect_val(1, 16'h0000, "R3 core counts down");
        step(1);
        expect_val(1, 16'h0005, "R3 underflow reloads");
        expect_val(7, 16'h1, "R3 toggle after underflow");
        reg_wr(3'd0, 16'h0000);
        t = 1'b1;

        // R4 R5 R6 R7 counter mode fed by the toggle latch
        reg_wr(3'd2, 16'hFFFC);
        for (int i = 0; i < 5; i++) begin
            bit tt;
            int r, f;
            tt = t; r = 0; f = 0;
            for (int k = 0; k < 3; k++) begin
                tt = ~tt;
                if (tt) r++; else f++;
            end
            if (modes[i] != 1)     exp = 16'd0;
            else if (srcs[i] == 5) exp = 16'(r);
            else if (srcs[i] == 6) exp = 16'(f);
            else if (srcs[i] == 7) exp = 16'd3;
            else                   exp = 16'd0;
            reg_wr(3'd3, 16'h0000);
            reg_wr(3'd4, 16'h0000);
            reg_wr(3'd3, aux_word(modes[i], srcs[i], 1'b1, 1'b0, 0, 1'b0));
            reg_wr(3'd1, 16'hFFFF);
            reg_wr(3'd0, 16'h0001);
            step(10);
            if (modes[i] != 1 || srcs[i] < 5)
                expect_val(4, exp, "R7 reserved source or mode does not count");
            else if (srcs[i] == 5)
                expect_val(4, exp, "R4 rising toggle edges counted");
            else if (srcs[i] == 6)
                expect_val(4, exp, "R5 falling toggle edges counted");
            else
                expect_val(4, exp, "R6 all toggle edges counted");
            reg_wr(3'd0, 16'h0000);
            t = tt;
            expect_val(7, {15'b0, t}, "R2 toggle parity after three overflows");
        end

        // R8 timer mode with prescaler
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd4, 16'h0000);
        reg_wr(3'd3, aux_word(0, 0, 1'b1, 1'b0, 2, 1'b0));
        step(16);
        expect_val(4, 16'd4, "R8 prescale 4 over 16 clocks");
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd4, 16'h0000);
        reg_wr(3'd3, aux_word(0, 0, 1'b1, 1'b0, 0, 1'b0));
        step(7);
        expect_val(4, 16'd7, "R8 prescale 1 over 7 clocks");

        // R12 R9 down count wrap
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd6, 16'h0000);
        reg_wr(3'd4, 16'h0001);
        reg_wr(3'd3, aux_word(0, 0, 1'b1, 1'b1, 0, 1'b0));
        step(1);
        expect_val(4, 16'h0000, "R12 down step");
        expect_val(8, 16'h0, "R9 no request before wrap");
        step(1);
        expect_val(4, 16'hFFFF, "R12 down wrap value");
        expect_val(8, 16'h1, "R9 request after down wrap");
        expect_val(6, {13'b0, t, 2'b01}, "R9 flag word after wrap");
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd6, 16'h0000);
        expect_val(8, 16'h0, "R9 request cleared by write");
        reg_wr(3'd4, 16'hFFFE);
        reg_wr(3'd3, aux_word(0, 0, 1'b1, 1'b0, 0, 1'b0));
        step(1);
        expect_val(8, 16'h0, "R9 no request at all ones");
        step(1);
        expect_val(4, 16'h0000, "R9 up wrap value");
        expect_val(8, 16'h1, "R9 request after up wrap");

        // R11 write wins over a due step
        reg_wr(3'd4, 16'h1234);
        expect_val(4, 16'h1234, "R11 written value kept");
        step(1);
        expect_val(4, 16'h1235, "R11 counting resumes");

        // R10 capture against a concurrent step
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd6, 16'h0000);
        reg_wr(3'd3, aux_word(0, 0, 1'b1, 1'b0, 0, 1'b1));
        reg_wr(3'd4, 16'h0100);
        cap_evt = 1'b1;
        step(1);
        cap_evt = 1'b0;
        expect_val(5, 16'h0100, "R10 capture holds pre-step count");
        expect_val(9, 16'h1, "R10 capture request");
        expect_val(4, 16'h0101, "R10 count stepped with capture");
        reg_wr(3'd3, 16'h0000);
        reg_wr(3'd6, 16'h0000);
        reg_wr(3'd5, 16'hFFFF);
        expect_val(5, 16'h0100, "R10 capture register ignores write");
        cap_evt = 1'b1;
        step(2);
        cap_evt = 1'b0;
        step(1);
        expect_val(5, 16'h0100, "R10 disabled capture ignored");
        expect_val(9, 16'h0, "R10 no request when disabled");

        finish_run();
    end
endmodule